// File: doc/BRIEF.md
# Split Request Queue With Bypass

This block is the refill-request queue that sits between two levels of a single-cell-per-level merge tree. The upstream cell pushes the ID of the FIFO it just drained. The downstream cell executes requests one at a time from the queue head. For each request, an address generator reads two records from a memory whose read data arrives one cycle after the address. If only the head were shown to the address generator, the consumer could act at most every other cycle.

The queue is built from two parts. A parameterised main body receives overflow. A two-entry front section holds the oldest two requests. The address output always names the request that will be at the head on the next cycle. While the consumer fires, that is the entry behind the head. While the consumer waits, for example when its own output queue is full, that is the head itself, so the records already fetched stay valid. When nothing suitable is stored, an arriving request is forwarded to the address output in the same cycle. With this arrangement the consumer can execute one request every cycle.

Top module: `split_req_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid`, `addr_valid` and `full` are all 0.
- R2: `head_id` shows the oldest accepted request that is still stored, and requests leave in the order they were accepted.
- R3: The queue stores up to DEPTH+2 requests. `full` is 1 exactly when DEPTH+2 requests are stored. A push offered while `full` is 1 is not stored, even in a cycle that also pops.
- R4: In a cycle where a request is popped and a new one is accepted, the occupancy does not change.
- R5: The head is popped only when `cell_go` is 1 and `dn_full` is 0. When `dn_full` is 1, the head is kept and `addr_id` shows the head.
- R6: While the head is popped and at least two requests are stored, `addr_id` shows the second-oldest request.
- R7: An accepted push is forwarded to `addr_id` in the same cycle in two cases: when the queue is empty and not popping, and when it holds one request that is being popped.
- R8: `addr_valid` is 0 when no request will be at the head on the next cycle, whether stored or arriving.
- R9: `cell_go` while the queue is empty has no effect.

Request IDs are $clog2(NFIFO) bits wide, with the ID value passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Upstream offers a refill request |
| push_id | input | ID_W | FIFO ID of the offered request |
| full | output | 1 | Queue holds DEPTH+2 requests; pushes are refused |
| cell_go | input | 1 | Consumer wants to execute the head this cycle |
| dn_full | input | 1 | Consumer's output queue is full; consumer stalls |
| head_valid | output | 1 | A request is at the head |
| head_id | output | ID_W | Request being executed |
| addr_valid | output | 1 | `addr_id` is meaningful |
| addr_id | output | ID_W | Request whose records are fetched for the next cycle |

## Verification
The bench sweeps the queue through every occupancy from empty to full, varying the push, go and stall densities. It goes after four kinds of error: addressing the head instead of the second entry while firing, which would halve throughput and misalign fetched data; forgetting the same-cycle bypass at occupancy 0 or 1, which would show a stale or invalid address; losing the head during a stall; and accepting a push at full or miscounting a simultaneous push and pop, which shows up later as a wrong order or a wrong `full`. Every cycle the bench compares the head, the address and `full` against an array model of the queue.

// File: rtl/rq_pkg.sv
package rq_pkg;
    // Which stored or arriving request drives the address output.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HEAD   = 2'd1,
        SRC_NEXT   = 2'd2,
        SRC_BYPASS = 2'd3
    } addr_src_e;
endpackage

// File: rtl/rq_body_fifo.sv
// Main body of the queue: circular buffer that receives overflow.
module rq_body_fifo #(
    parameter  int ID_W  = 3,
    parameter  int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ID_W-1:0]  wr_id,
    input  logic             rd_en,
    output logic [ID_W-1:0]  rd_id,
    output logic             empty,
    output logic [CNT_W-1:0] level
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } body_st_t;

    body_st_t        st_d, st_q;
    logic [ID_W-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.wp = bump(st_q.wp);
        if (rd_en) st_d.rp = bump(st_q.rp);
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[st_q.wp] <= wr_id;
    end

    assign rd_id = mem_q[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign level = st_q.cnt;
endmodule

// File: rtl/rq_front_pair.sv
// Two-entry front section: slot0 is the head, slot1 the request behind it.
module rq_front_pair #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            load_en,
    input  logic [ID_W-1:0] load_id,
    output logic [1:0]      cnt,
    output logic [ID_W-1:0] slot0,
    output logic [ID_W-1:0] slot1
);
    typedef struct packed {
        logic [ID_W-1:0] s0;
        logic [ID_W-1:0] s1;
        logic [1:0]      n;
    } front_st_t;

    front_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.s0 = st_q.s1;
            st_d.n  = st_q.n - 2'd1;
        end
        if (load_en) begin
            if (st_d.n == 2'd0) st_d.s0 = load_id;
            else                st_d.s1 = load_id;
            st_d.n = st_d.n + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt   = st_q.n;
    assign slot0 = st_q.s0;
    assign slot1 = st_q.s1;
endmodule

// File: rtl/rq_addr_sel.sv
// Picks the request that will be the head on the next cycle.
module rq_addr_sel
    import rq_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            fire,
    input  logic [1:0]      front_cnt,
    input  logic [ID_W-1:0] s0,
    input  logic [ID_W-1:0] s1,
    input  logic            byp_valid,
    input  logic [ID_W-1:0] byp_id,
    output addr_src_e       src,
    output logic            addr_valid,
    output logic [ID_W-1:0] addr_id
);
    always_comb begin
        src = SRC_NONE;
        if (fire) begin
            if (front_cnt == 2'd2) src = SRC_NEXT;
            else if (byp_valid)    src = SRC_BYPASS;
        end else begin
            if (front_cnt != 2'd0) src = SRC_HEAD;
            else if (byp_valid)    src = SRC_BYPASS;
        end
    end

    always_comb begin
        addr_valid = (src != SRC_NONE);
        case (src)
            SRC_HEAD:   addr_id = s0;
            SRC_NEXT:   addr_id = s1;
            SRC_BYPASS: addr_id = byp_id;
            default:    addr_id = '0;
        endcase
    end
endmodule

// File: rtl/split_req_queue.sv
module split_req_queue
    import rq_pkg::*;
#(
    parameter  int NFIFO = 8,
    parameter  int DEPTH = 4,
    localparam int ID_W  = (NFIFO > 1) ? $clog2(NFIFO) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_valid,
    input  logic [ID_W-1:0] push_id,
    output logic            full,
    input  logic            cell_go,
    input  logic            dn_full,
    output logic            head_valid,
    output logic [ID_W-1:0] head_id,
    output logic            addr_valid,
    output logic [ID_W-1:0] addr_id
);
    localparam int CAP   = DEPTH + 2;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int OCC_W = $clog2(CAP + 1);

    typedef struct packed {
        logic fire;
        logic accept;
        logic room;
        logic body_wr;
        logic body_rd;
        logic load_en;
    } ctl_t;

    ctl_t             ctl;
    logic [1:0]       front_cnt;
    logic [ID_W-1:0]  s0, s1, body_id, load_id;
    logic             body_empty;
    logic [CNT_W-1:0] body_lvl;
    logic [OCC_W-1:0] occ;
    addr_src_e        src;

    assign occ        = OCC_W'(front_cnt) + OCC_W'(body_lvl);
    assign full       = (occ == OCC_W'(CAP));
    assign head_valid = (front_cnt != 2'd0);
    assign head_id    = s0;

    // The body only holds entries while the front pair is full, so at most
    // one request (arrival or body head) moves into the front per cycle.
    always_comb begin
        ctl         = '0;
        ctl.fire    = cell_go && !dn_full && head_valid;
        ctl.accept  = push_valid && !full;
        ctl.room    = (front_cnt != 2'd2) || ctl.fire;
        ctl.body_rd = ctl.fire && !body_empty;
        ctl.body_wr = ctl.accept && !(body_empty && ctl.room);
        ctl.load_en = (ctl.accept && body_empty && ctl.room) || ctl.body_rd;
        load_id     = body_empty ? push_id : body_id;
    end

    rq_body_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) body_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl.body_wr),
        .wr_id (push_id),
        .rd_en (ctl.body_rd),
        .rd_id (body_id),
        .empty (body_empty),
        .level (body_lvl)
    );

    rq_front_pair #(.ID_W(ID_W)) front_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (ctl.fire),
        .load_en (ctl.load_en),
        .load_id (load_id),
        .cnt     (front_cnt),
        .slot0   (s0),
        .slot1   (s1)
    );

    rq_addr_sel #(.ID_W(ID_W)) sel_i (
        .fire       (ctl.fire),
        .front_cnt  (front_cnt),
        .s0         (s0),
        .s1         (s1),
        .byp_valid  (ctl.accept),
        .byp_id     (push_id),
        .src        (src),
        .addr_valid (addr_valid),
        .addr_id    (addr_id)
    );
endmodule

// File: rtl/split_req_queue_chk.sv
module split_req_queue_chk #(
    parameter int ID_W  = 3,
    parameter int DEPTH = 4,
    parameter int OCC_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_valid,
    input logic [ID_W-1:0] push_id,
    input logic            full,
    input logic            cell_go,
    input logic            dn_full,
    input logic            head_valid,
    input logic [ID_W-1:0] head_id,
    input logic            addr_valid,
    input logic [ID_W-1:0] addr_id,
    input logic [OCC_W-1:0] occ
);
    logic pop_now, take_now;
    assign pop_now  = cell_go && !dn_full && head_valid;
    assign take_now = push_valid && !full;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_W'(DEPTH + 2));

    a_r3_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> occ <= $past(occ));

    a_r4_push_pop_steady: assert property (@(posedge clk) disable iff (!rst_n)
        pop_now && take_now |=> occ == $past(occ));

    a_r5_stall_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid && !pop_now |=> head_valid && head_id == $past(head_id));

    a_r5_stall_addr_head: assert property (@(posedge clk) disable iff (!rst_n)
        head_valid && dn_full |-> addr_valid && addr_id == head_id);

    a_r6_addr_predicts_head: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> head_valid && head_id == $past(addr_id));

    a_r8_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid && !take_now |-> !addr_valid);

    a_r9_go_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid && !take_now |=> !head_valid);
endmodule

bind split_req_queue split_req_queue_chk #(
    .ID_W(ID_W), .DEPTH(DEPTH), .OCC_W(OCC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_id    (push_id),
    .full       (full),
    .cell_go    (cell_go),
    .dn_full    (dn_full),
    .head_valid (head_valid),
    .head_id    (head_id),
    .addr_valid (addr_valid),
    .addr_id    (addr_id),
    .occ        (occ)
);

// File: tb/split_req_queue_tb_top.sv
module split_req_queue_tb_top;
    localparam int CLK_P = 10;
    localparam int NFIFO = 8;
    localparam int DEPTH = 4;
    localparam int ID_W  = 3;
    localparam int CAP   = DEPTH + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_valid = 1'b0;
    logic [ID_W-1:0] push_id = '0;
    logic            cell_go = 1'b0;
    logic            dn_full = 1'b0;
    logic            full, head_valid, addr_valid;
    logic [ID_W-1:0] head_id, addr_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [ID_W-1:0] mq [CAP];
    int   mcnt = 0;
    bit   prev_both = 1'b0;
    bit   prev_go_empty = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    split_req_queue #(.NFIFO(NFIFO), .DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_id    (push_id),
        .full       (full),
        .cell_go    (cell_go),
        .dn_full    (dn_full),
        .head_valid (head_valid),
        .head_id    (head_id),
        .addr_valid (addr_valid),
        .addr_id    (addr_id)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit go, input bit dnf, input bit pv, input logic [ID_W-1:0] id);
        bit fire, acc;
        @(negedge clk);
        cell_go = go; dn_full = dnf; push_valid = pv; push_id = id;
        #1;
        fire = go && !dnf && (mcnt > 0);
        acc  = pv && (mcnt < CAP);
        chk(prev_go_empty ? "R9 head_valid" : "R2 head_valid", 8'(head_valid), 8'(mcnt > 0));
        if (mcnt > 0) chk("R2 head_id", 8'(head_id), 8'(mq[0]));
        chk(prev_both ? "R4 full" : "R3 full", 8'(full), 8'(mcnt == CAP));
        if (fire && mcnt >= 2) begin
            chk("R6 addr_valid", 8'(addr_valid), 8'd1);
            chk("R6 addr_id", 8'(addr_id), 8'(mq[1]));
        end else if (fire && acc) begin
            chk("R7 addr_valid", 8'(addr_valid), 8'd1);
            chk("R7 addr_id", 8'(addr_id), 8'(id));
        end else if (fire) begin
            chk("R8 addr_valid", 8'(addr_valid), 8'd0);
        end else if (mcnt > 0) begin
            chk(dnf ? "R5 addr_valid" : "R2 addr_valid", 8'(addr_valid), 8'd1);
            chk(dnf ? "R5 addr_id" : "R2 addr_id", 8'(addr_id), 8'(mq[0]));
        end else if (acc) begin
            chk("R7 addr_valid", 8'(addr_valid), 8'd1);
            chk("R7 addr_id", 8'(addr_id), 8'(id));
        end else begin
            chk("R8 addr_valid", 8'(addr_valid), 8'd0);
        end
        @(posedge clk);
        prev_both     = fire && acc;
        prev_go_empty = go && (mcnt == 0);
        if (fire) begin
            for (int i = 0; i < CAP - 1; i++) mq[i] = mq[i + 1];
            mcnt--;
        end
        if (acc) begin
            mq[mcnt] = id;
            mcnt++;
        end
    endtask

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 head_valid", 8'(head_valid), 8'd0);
        chk("R1 addr_valid", 8'(addr_valid), 8'd0);
        chk("R1 full", 8'(full), 8'd0);
        // directed: idle bypass, pop, go on empty (R9)
        step(1'b0, 1'b0, 1'b1, 3'd5);
        step(1'b1, 1'b0, 1'b0, 3'd0);
        step(1'b1, 1'b0, 1'b0, 3'd0);
        step(1'b0, 1'b0, 1'b0, 3'd0);
        // fill past capacity (R3): last two pushes are refused
        for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b0, 1'b1, ID_W'(i));
        // pop with push offered while full: refused (R3)
        step(1'b1, 1'b0, 1'b1, 3'd7);
        // stalls with pushes (R5), then push+pop at full-1 (R4)
        step(1'b1, 1'b1, 1'b1, 3'd6);
        step(1'b1, 1'b1, 1'b0, 3'd0);
        step(1'b1, 1'b0, 1'b1, 3'd2);
        step(1'b1, 1'b0, 1'b1, 3'd3);
        // drain with back-to-back pops (R6) then one-entry bypass (R7)
        for (int i = 0; i < CAP + 1; i++) step(1'b1, 1'b0, 1'b0, 3'd0);
        step(1'b0, 1'b0, 1'b1, 3'd4);
        step(1'b1, 1'b0, 1'b1, 3'd1);
        step(1'b1, 1'b0, 1'b1, 3'd6);
        // swept traffic densities
        for (int ph = 0; ph < 4; ph++) begin
            for (int c = 0; c < 2000; c++) begin
                bit go, dnf, pv;
                lfsr = nxt(lfsr);
                case (ph)
                    0: begin pv = lfsr[3:0] < 4'd12; go = lfsr[7:4] < 4'd5;  dnf = 1'b0; end
                    1: begin pv = lfsr[3:0] < 4'd8;  go = lfsr[7:4] < 4'd8;  dnf = lfsr[11:8] < 4'd3; end
                    2: begin pv = lfsr[3:0] < 4'd5;  go = lfsr[7:4] < 4'd13; dnf = 1'b0; end
                    default: begin pv = lfsr[3:0] < 4'd10; go = 1'b1; dnf = lfsr[11:8] < 4'd7; end
                endcase
                step(go, dnf, pv, lfsr[14:12]);
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (R2 progress) actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule